// File: doc/BRIEF.md
# Power-On Request Arbiter

This block decides when a power controller starts and stops its power-up sequence. It watches one shared control pin. The pin can be read in one of three ways: as a level enable, as an active-low push-button, or as the output of a supply-good comparator. The block filters the pin with deglitch timers that count ticks of a slow enable strobe. It combines the filtered pin with a supply power-on-reset flag, a register-issued off command, shutdown-fault and cold-reset events, and a first-supply-detect option. From these it emits one-cycle power-up and power-down requests to the sequencer.

The block remembers why the rail was last switched off.
- After a fault or a cold reset, the pin is treated as level-sensitive, so the block restarts by itself while the pin is still at its on level.
- After a register off command or a pin-initiated off, a fresh on-request is required.

With first-supply-detect enabled, the first power-up after the supply flag rises ignores the pin. The pin is then assumed valid until the sequencer reports ACTIVE. Two write-one-to-clear status bits record whether a power-up came from the pin or from first-supply-detect.

Top module: `por_request_arbiter`

## Requirements
- R1: In enable mode (`mode_i`=00, or 11), power-up is requested only after the pin has stayed high for `RISE_TICKS[degl_sel_i]` strobe ticks. A shorter high pulse is ignored.
- R2: In enable mode, power-down is requested only after the pin has stayed low for `FALL_TICKS[degl_sel_i]` ticks. A shorter low pulse is ignored.
- R3: In button mode (`mode_i`=01, pin low = pressed), power-up needs a press held for `RISE_TICKS[degl_sel_i]` ticks. A shorter press is ignored, and a release must last `BTN_REL_TICKS` ticks before it counts.
- R4: In button mode, a press held for `BTN_OFF_TICKS` ticks while powered requests power-down. A further power-up then needs a release followed by a new valid press.
- R5: In button mode, no press is counted while `vsys_ok_i` is low. A press held across the rise of `vsys_ok_i` powers up once the on-time has elapsed after that rise.
- R6: In sense mode (`mode_i`=10, high = supply good), power-up is requested within two clock cycles of the pin rising, with no deglitch. Power-down needs the pin low for `FALL_TICKS[degl_sel_i]` ticks.
- R7: A fault or cold-reset pulse while powered requests power-down. The block then re-requests power-up by itself: if the filtered pin is at its on level in enable or sense mode, and always in button mode.
- R8: A register off pulse while powered requests power-down. In enable or sense mode, a new power-up then needs the pin to go low for `REG_OFF_FALL_TICKS` ticks and rise again. In button mode it needs a new press.
- R9: With `fsd_en_i` high, a rise of `vsys_ok_i` requests power-up whatever the pin state. A pin at its off level is then ignored until `active_i` pulses, after which the filtered pin is followed.
- R10: A pin-caused power-up sets `cause_pin_o`, and a first-supply-detect power-up sets `cause_fsd_o`. Each bit stays set until its clear strobe is pulsed.
- R11: Requests are single-cycle pulses that never coincide and strictly alternate, starting with power-up. Power-up is held back while `dn_busy_i` is high. Power-down, including a latched register off, is held back while `up_busy_i` is high.
- R12: No power-up is requested while `vsys_ok_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow strobe that paces all deglitch timers |
| pin_i | input | 1 | Synchronized control pin |
| mode_i | input | 2 | Pin interpretation: 00 enable, 01 button, 10 sense, 11 enable |
| degl_sel_i | input | 2 | Index into the rise and fall deglitch tables |
| vsys_ok_i | input | 1 | Supply power-on-reset flag |
| fsd_en_i | input | 1 | First-supply-detect enable |
| reg_off_i | input | 1 | Register-issued off command pulse |
| fault_i | input | 1 | Shutdown fault pulse |
| cold_rst_i | input | 1 | Cold reset pulse |
| active_i | input | 1 | Sequencer has reached ACTIVE |
| up_busy_i | input | 1 | Power-up sequence in progress |
| dn_busy_i | input | 1 | Power-down sequence in progress |
| clr_pin_cause_i | input | 1 | Write-one-to-clear strobe for the pin cause bit |
| clr_fsd_cause_i | input | 1 | Write-one-to-clear strobe for the first-supply cause bit |
| pwr_up_o | output | 1 | Power-up request pulse |
| pwr_dn_o | output | 1 | Power-down request pulse |
| cause_pin_o | output | 1 | Last power-up came from the pin |
| cause_fsd_o | output | 1 | Last power-up came from first-supply-detect |

## Verification
The bench targets the three places where the off-cause memory matters.

- **Fault or cold reset while the pin stays on.** A design that kept the pin edge-sensitive here would never restart.
- **Register off with the pin left high.** A design that stayed level-sensitive would bounce straight back on.
- **Button held after a long-press off.** A design that reacted to the filtered level rather than a new press would power up again without a release.

Two more corners are covered:
- The deglitch boundaries are checked one tick short of and one tick past each length, and a sense-mode rise must come through within a few cycles.
- The first-supply-detect hold is checked with the pin low. A missing hold powers down before ACTIVE, and a hold that never ends never powers down.

// File: rtl/por_arb_pkg.sv
package por_arb_pkg;

  typedef enum logic [1:0] {
    PIN_EN    = 2'b00,
    PIN_BTN   = 2'b01,
    PIN_SENSE = 2'b10
  } pin_mode_e;

  function automatic pin_mode_e decode_mode(input logic [1:0] raw);
    case (raw)
      2'b01:   return PIN_BTN;
      2'b10:   return PIN_SENSE;
      default: return PIN_EN;
    endcase
  endfunction

endpackage

// File: rtl/por_deglitch.sv
// Two-sided level filter paced by a tick strobe; optional instant rise.
module por_deglitch #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             raw_i,
  input  logic             bypass_rise_i,
  input  logic [CNT_W-1:0] rise_len_i,
  input  logic [CNT_W-1:0] fall_len_i,
  output logic             lvl_o
);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, len;
  logic             lvl_q;

  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign len     = raw_i ? rise_len_i : fall_len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (bypass_rise_i && raw_i && !lvl_q) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else if (raw_i == lvl_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_nxt >= len) begin
        lvl_q <= raw_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/por_hold_timer.sv
// Fires one pulse when raw_i has been high for LIMIT ticks.
module por_hold_timer #(
  parameter int               CNT_W = 6,
  parameter logic [CNT_W-1:0] LIMIT = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic raw_i,
  output logic fire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else if (!en_i || !raw_i) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= tick_i && (cnt_q == LIMIT - CNT_W'(1));
      if (tick_i && cnt_q < LIMIT) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign fire_o = fire_q;

endmodule

// File: rtl/por_arb_core.sv
// Power state, off-cause memory, first-supply hold and request issue.
module por_arb_core
  import por_arb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pin_mode_e mode_i,
  input  logic      filt_i,
  input  logic      long_evt_i,
  input  logic      vsys_ok_i,
  input  logic      fsd_en_i,
  input  logic      reg_off_i,
  input  logic      fault_i,
  input  logic      cold_rst_i,
  input  logic      active_i,
  input  logic      up_busy_i,
  input  logic      dn_busy_i,
  input  logic      clr_pin_i,
  input  logic      clr_fsd_i,
  output logic      up_o,
  output logic      dn_o,
  output logic      cause_pin_o,
  output logic      cause_fsd_o,
  output logic      need_edge_o
);

  logic on_q, need_edge_q, vsys_q, filt_q;
  logic fsd_pend_q, fsd_hold_q;
  logic reg_off_q, restart_q, long_q;
  logic up_q, dn_q, cause_pin_q, cause_fsd_q;
  logic btn, press_evt, up_pin, pin_off, do_up, do_dn;

  assign btn       = (mode_i == PIN_BTN);
  assign press_evt = btn && filt_i && !filt_q;
  // Edge-armed: a press (button) or a filtered low (level modes) re-arms.
  assign up_pin    = !need_edge_q && (btn || filt_i);
  assign do_up     = !on_q && vsys_ok_i && !dn_busy_i && (fsd_pend_q || up_pin);
  assign pin_off   = !fsd_hold_q && (btn ? long_q : !filt_i);
  assign do_dn     = on_q && !up_busy_i && (reg_off_q || restart_q || pin_off);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q        <= 1'b0;
      need_edge_q <= 1'b1;
      vsys_q      <= 1'b0;
      filt_q      <= 1'b0;
      fsd_pend_q  <= 1'b0;
      fsd_hold_q  <= 1'b0;
      reg_off_q   <= 1'b0;
      restart_q   <= 1'b0;
      long_q      <= 1'b0;
      up_q        <= 1'b0;
      dn_q        <= 1'b0;
      cause_pin_q <= 1'b0;
      cause_fsd_q <= 1'b0;
    end else begin
      vsys_q <= vsys_ok_i;
      filt_q <= filt_i;
      up_q   <= do_up;
      dn_q   <= do_dn;

      if (do_up)      on_q <= 1'b1;
      else if (do_dn) on_q <= 1'b0;

      // Register off beats a simultaneous fault: stricter re-arm wins.
      if (do_dn)      need_edge_q <= reg_off_q || !restart_q;
      else if (do_up) need_edge_q <= 1'b0;
      else if (need_edge_q && (btn ? press_evt : !filt_i)) need_edge_q <= 1'b0;

      if (do_up) fsd_pend_q <= 1'b0;
      else if (vsys_ok_i && !vsys_q && fsd_en_i) fsd_pend_q <= 1'b1;

      if (do_up) fsd_hold_q <= fsd_pend_q;
      else if (do_dn || active_i) fsd_hold_q <= 1'b0;

      if (do_dn) begin
        reg_off_q <= 1'b0;
        restart_q <= 1'b0;
        long_q    <= 1'b0;
      end else if (on_q) begin
        if (reg_off_i) reg_off_q <= 1'b1;
        if (fault_i || cold_rst_i) restart_q <= 1'b1;
        if (long_evt_i && btn && !fsd_hold_q) long_q <= 1'b1;
      end

      if (do_up && !fsd_pend_q) cause_pin_q <= 1'b1;
      else if (clr_pin_i)       cause_pin_q <= 1'b0;
      if (do_up && fsd_pend_q)  cause_fsd_q <= 1'b1;
      else if (clr_fsd_i)       cause_fsd_q <= 1'b0;
    end
  end

  assign up_o        = up_q;
  assign dn_o        = dn_q;
  assign cause_pin_o = cause_pin_q;
  assign cause_fsd_o = cause_fsd_q;
  assign need_edge_o = need_edge_q;

endmodule

// File: rtl/por_request_arbiter.sv
module por_request_arbiter
  import por_arb_pkg::*;
#(
  parameter int                    CNT_W              = 6,
  parameter logic [3:0][CNT_W-1:0] RISE_TICKS         = {6'd16, 6'd8, 6'd4, 6'd2},
  parameter logic [3:0][CNT_W-1:0] FALL_TICKS         = {6'd24, 6'd12, 6'd6, 6'd3},
  parameter logic [CNT_W-1:0]      REG_OFF_FALL_TICKS = 6'd1,
  parameter logic [CNT_W-1:0]      BTN_REL_TICKS      = 6'd2,
  parameter logic [CNT_W-1:0]      BTN_OFF_TICKS      = 6'd40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] degl_sel_i,
  input  logic       vsys_ok_i,
  input  logic       fsd_en_i,
  input  logic       reg_off_i,
  input  logic       fault_i,
  input  logic       cold_rst_i,
  input  logic       active_i,
  input  logic       up_busy_i,
  input  logic       dn_busy_i,
  input  logic       clr_pin_cause_i,
  input  logic       clr_fsd_cause_i,
  output logic       pwr_up_o,
  output logic       pwr_dn_o,
  output logic       cause_pin_o,
  output logic       cause_fsd_o
);

  pin_mode_e        mode;
  logic             btn, sense, raw_on, filt, long_evt, need_edge;
  logic [CNT_W-1:0] rise_len, fall_len;

  assign mode     = decode_mode(mode_i);
  assign btn      = (mode == PIN_BTN);
  assign sense    = (mode == PIN_SENSE);
  assign raw_on   = btn ? !pin_i : pin_i;
  assign rise_len = RISE_TICKS[degl_sel_i];
  assign fall_len = btn       ? BTN_REL_TICKS :
                    need_edge ? REG_OFF_FALL_TICKS : FALL_TICKS[degl_sel_i];

  por_deglitch #(.CNT_W(CNT_W)) u_degl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (vsys_ok_i),
    .tick_i        (tick_i),
    .raw_i         (raw_on),
    .bypass_rise_i (sense),
    .rise_len_i    (rise_len),
    .fall_len_i    (fall_len),
    .lvl_o         (filt)
  );

  por_hold_timer #(.CNT_W(CNT_W), .LIMIT(BTN_OFF_TICKS)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (vsys_ok_i && btn),
    .tick_i (tick_i),
    .raw_i  (raw_on),
    .fire_o (long_evt)
  );

  por_arb_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .filt_i      (filt),
    .long_evt_i  (long_evt),
    .vsys_ok_i   (vsys_ok_i),
    .fsd_en_i    (fsd_en_i),
    .reg_off_i   (reg_off_i),
    .fault_i     (fault_i),
    .cold_rst_i  (cold_rst_i),
    .active_i    (active_i),
    .up_busy_i   (up_busy_i),
    .dn_busy_i   (dn_busy_i),
    .clr_pin_i   (clr_pin_cause_i),
    .clr_fsd_i   (clr_fsd_cause_i),
    .up_o        (pwr_up_o),
    .dn_o        (pwr_dn_o),
    .cause_pin_o (cause_pin_o),
    .cause_fsd_o (cause_fsd_o),
    .need_edge_o (need_edge)
  );

endmodule

// File: rtl/por_request_arbiter_chk.sv
module por_request_arbiter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic vsys_ok_i,
  input logic dn_busy_i,
  input logic up_busy_i,
  input logic pwr_up_o,
  input logic pwr_dn_o,
  input logic cause_pin_o,
  input logic cause_fsd_o
);

  logic powered_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       powered_q <= 1'b0;
    else if (pwr_up_o) powered_q <= 1'b1;
    else if (pwr_dn_o) powered_q <= 1'b0;
  end

  // R11
  up_dn_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwr_up_o && pwr_dn_o));

  // R11
  up_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_up_o |=> !pwr_up_o);

  // R11
  dn_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_o |=> !pwr_dn_o);

  // R11
  up_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_up_o |-> !powered_q);

  // R11
  dn_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_o |-> powered_q);

  // R11
  up_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_up_o) |-> $past(!dn_busy_i));

  // R11
  dn_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_dn_o) |-> $past(!up_busy_i));

  // R12
  up_needs_vsys_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_up_o) |-> $past(vsys_ok_i));

  // R10
  cause_pin_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_pin_o) |-> pwr_up_o);

  // R10
  cause_fsd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_fsd_o) |-> pwr_up_o);

endmodule

bind por_request_arbiter por_request_arbiter_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vsys_ok_i   (vsys_ok_i),
  .dn_busy_i   (dn_busy_i),
  .up_busy_i   (up_busy_i),
  .pwr_up_o    (pwr_up_o),
  .pwr_dn_o    (pwr_dn_o),
  .cause_pin_o (cause_pin_o),
  .cause_fsd_o (cause_fsd_o)
);

// File: tb/tb_por_request_arbiter.sv
`timescale 1ns/1ps
module tb_por_request_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] div = 2'd0;
  logic       pin = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] sel = 2'b00;
  logic       vsys = 1'b0, fsd = 1'b0, reg_off = 1'b0, fault = 1'b0, cold = 1'b0;
  logic       active = 1'b0, up_busy = 1'b0, dn_busy = 1'b0, clr_pin = 1'b0, clr_fsd = 1'b0;
  logic       pwr_up, pwr_dn, cause_pin, cause_fsd;

  int up_cnt = 0, dn_cnt = 0, tests = 0, fails = 0, cycles = 0;

  por_request_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pin_i(pin), .mode_i(mode),
    .degl_sel_i(sel), .vsys_ok_i(vsys), .fsd_en_i(fsd), .reg_off_i(reg_off),
    .fault_i(fault), .cold_rst_i(cold), .active_i(active), .up_busy_i(up_busy),
    .dn_busy_i(dn_busy), .clr_pin_cause_i(clr_pin), .clr_fsd_cause_i(clr_fsd),
    .pwr_up_o(pwr_up), .pwr_dn_o(pwr_dn), .cause_pin_o(cause_pin), .cause_fsd_o(cause_fsd)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
    if (pwr_up) up_cnt++;
    if (pwr_dn) dn_cnt++;
    cycles++;
  end

  always @(posedge clk) begin
    if (cycles == 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (4 * n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [1:0] s,
                          input logic p, input logic v, input logic f);
    @(negedge clk);
    rst_n = 1'b0;
    mode = m; sel = s; pin = p; vsys = v; fsd = f;
    reg_off = 0; fault = 0; cold = 0; active = 0;
    up_busy = 0; dn_busy = 0; clr_pin = 0; clr_fsd = 0;
    cyc(3);
    up_cnt = 0; dn_cnt = 0;
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset;
    do_reset(2'b00, 2'b00, 1'b0, 1'b1, 1'b0);
    chk("R11 reset no up", int'(pwr_up), 0);
    chk("R11 reset no dn", int'(pwr_dn), 0);
    chk("R10 reset cause_pin", int'(cause_pin), 0);
    chk("R10 reset cause_fsd", int'(cause_fsd), 0);
  endtask

  task automatic t_enable;
    do_reset(2'b00, 2'b01, 1'b0, 1'b1, 1'b0); // rise 4, fall 6
    pin = 1; ticks(2); pin = 0; ticks(3);
    chk("R1 short high ignored", up_cnt, 0);
    pin = 1; ticks(3);
    chk("R1 no up before rise time", up_cnt, 0);
    ticks(2);
    chk("R1 up after rise time", up_cnt, 1);
    chk("R10 pin cause set", int'(cause_pin), 1);
    chk("R10 fsd cause clear", int'(cause_fsd), 0);
    clr_pin = 1; cyc(1); clr_pin = 0; cyc(1);
    chk("R10 pin cause cleared", int'(cause_pin), 0);
    pin = 0; ticks(3); pin = 1; ticks(4);
    chk("R2 short low ignored", dn_cnt, 0);
    pin = 0; ticks(5);
    chk("R2 no dn before fall time", dn_cnt, 0);
    ticks(2);
    chk("R2 dn after fall time", dn_cnt, 1);
  endtask

  task automatic t_btn_bounce;
    do_reset(2'b01, 2'b00, 1'b1, 1'b1, 1'b0); // on-time 2
    pin = 0; cyc(4); pin = 1; ticks(3);
    chk("R3 short press ignored", up_cnt, 0);
    pin = 0; ticks(3); pin = 1;
    ticks(1);
    chk("R3 valid press powers up", up_cnt, 1);
  endtask

  task automatic t_btn_vsys;
    do_reset(2'b01, 2'b00, 1'b0, 1'b0, 1'b0);
    ticks(10);
    chk("R12 no up while vsys low", up_cnt, 0);
    vsys = 1; ticks(1);
    chk("R5 held press waits after vsys rise", up_cnt, 0);
    ticks(3);
    chk("R5 held press counts after vsys", up_cnt, 1);
    pin = 1; ticks(4);
    pin = 0; ticks(38);
    chk("R4 no dn before long hold", dn_cnt, 0);
    ticks(3);
    chk("R4 long hold powers down", dn_cnt, 1);
    ticks(5);
    chk("R4 held button gives no new up", up_cnt, 1);
    pin = 1; ticks(4); pin = 0; ticks(3); pin = 1; ticks(1);
    chk("R4 new press powers up", up_cnt, 2);
  endtask

  task automatic t_sense;
    do_reset(2'b10, 2'b10, 1'b0, 1'b1, 1'b0); // fall 12
    pin = 1; cyc(4);
    chk("R6 immediate up on rise", up_cnt, 1);
    pin = 0; ticks(10);
    chk("R6 no dn before fall time", dn_cnt, 0);
    ticks(4);
    chk("R6 dn after fall time", dn_cnt, 1);
  endtask

  task automatic t_fault;
    do_reset(2'b00, 2'b00, 1'b1, 1'b1, 1'b0);
    ticks(4);
    chk("R1 up for fault test", up_cnt, 1);
    fault = 1; cyc(1); fault = 0; cyc(8);
    chk("R7 fault powers down", dn_cnt, 1);
    chk("R7 auto restart after fault", up_cnt, 2);
    cold = 1; cyc(1); cold = 0; cyc(8);
    chk("R7 cold reset powers down", dn_cnt, 2);
    chk("R7 auto restart after cold reset", up_cnt, 3);
    do_reset(2'b01, 2'b00, 1'b1, 1'b1, 1'b0);
    pin = 0; ticks(3); pin = 1; ticks(3);
    chk("R3 button up for cold test", up_cnt, 1);
    cold = 1; cyc(1); cold = 0; cyc(8);
    chk("R7 button cold reset down", dn_cnt, 1);
    chk("R7 button restart without press", up_cnt, 2);
  endtask

  task automatic t_regoff;
    do_reset(2'b00, 2'b11, 1'b1, 1'b1, 1'b0); // rise 16, fall 24
    ticks(18);
    chk("R1 up for regoff test", up_cnt, 1);
    reg_off = 1; cyc(1); reg_off = 0; cyc(5);
    chk("R8 reg off powers down", dn_cnt, 1);
    ticks(10);
    chk("R8 high pin does not restart", up_cnt, 1);
    pin = 0; ticks(2); pin = 1; ticks(18);
    chk("R8 short low and new edge restarts", up_cnt, 2);
    do_reset(2'b01, 2'b00, 1'b1, 1'b1, 1'b0);
    pin = 0; ticks(3); pin = 1; ticks(3);
    chk("R3 button up for regoff test", up_cnt, 1);
    reg_off = 1; cyc(1); reg_off = 0; cyc(5);
    chk("R8 button reg off down", dn_cnt, 1);
    ticks(10);
    chk("R8 button no restart without press", up_cnt, 1);
    pin = 0; ticks(3); pin = 1; ticks(1);
    chk("R8 button new press restarts", up_cnt, 2);
  endtask

  task automatic t_fsd;
    do_reset(2'b00, 2'b00, 1'b0, 1'b0, 1'b1);
    vsys = 1; cyc(5);
    chk("R9 fsd up with pin low", up_cnt, 1);
    chk("R10 fsd cause set", int'(cause_fsd), 1);
    chk("R10 pin cause not set", int'(cause_pin), 0);
    ticks(10);
    chk("R9 low pin held off until active", dn_cnt, 0);
    active = 1; cyc(1); active = 0; cyc(5);
    chk("R9 low pin followed after active", dn_cnt, 1);
    clr_fsd = 1; cyc(1); clr_fsd = 0; cyc(1);
    chk("R10 fsd cause cleared", int'(cause_fsd), 0);
    ticks(4);
    chk("R9 no restart with low pin", up_cnt, 1);
  endtask

  task automatic t_busy;
    do_reset(2'b00, 2'b00, 1'b1, 1'b1, 1'b0);
    dn_busy = 1; ticks(5);
    chk("R11 up held while down busy", up_cnt, 0);
    dn_busy = 0; cyc(5);
    chk("R11 up after down busy", up_cnt, 1);
    up_busy = 1; reg_off = 1; cyc(1); reg_off = 0; cyc(6);
    chk("R11 dn held while up busy", dn_cnt, 0);
    up_busy = 0; cyc(5);
    chk("R11 latched off issued", dn_cnt, 1);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_btn_bounce();
    t_btn_vsys();
    t_sense();
    t_fault();
    t_regoff();
    t_fsd();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule